// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block times the two strobes of a byte-wide external memory bus on an 8051-class controller. A machine cycle lasts twelve oscillator clocks and is split into two six-clock halves. In each half the sequencer can raise the address latch strobe (ALE) for the external address latch, and it can pull the active-low program store enable strobe low to read external code memory. A free-running phase counter sets the position of every pulse within the cycle.

The CPU side states, once per machine cycle, whether that cycle is an instruction fetch or an external data access, and for a fetch it supplies the fetch address. The sequencer then decides whether the fetch is served from on-chip program memory or from the external bus. That decision depends on the external-access pin, which is latched once after reset, and on an 8K internal code boundary. A control bit can silence ALE entirely, for example to cut emissions.

Top module: `xbus_strobe_gen`

## Requirements
- R1: The phase counter runs through 12 phases, 0 to 11, and then wraps to 0. In a fetch cycle with ale_off_i low, ale_o is high in phases 0, 1, 6 and 7 and low in all other phases. This gives one ALE pulse every six clocks.
- R2: In a fetch cycle that is routed to external memory, psen_no is low in phases 2 to 4 and 8 to 10 and high in all other phases. ale_o and psen_no are never active at the same time.
- R3: In an external data cycle (req_data_i = 1), ale_o pulses only in phases 0 and 1, so the second pulse is dropped. psen_no stays high for the whole cycle, so both PSEN pulses are dropped, and ext_sel_o is 0.
- R4: In a fetch cycle routed to internal memory, psen_no stays high for the whole cycle, while ale_o keeps its normal pattern.
- R5: ext_sel_o is 1 for a fetch cycle when the latched EA level is 0, whatever the address. When the latched EA level is 1, ext_sel_o is 1 only if the fetch address is above 16'h1FFF.
- R6: While ale_off_i is high, ale_o stays low in every phase, and psen_no is not affected.
- R7: ea_i is sampled on the first rising clock edge after rst_ni is released. Later changes on ea_i do not affect routing until the next reset.
- R8: While rst_ni is low, ale_o is 0, psen_no is 1, ext_sel_o is 0 and the phase counter is held at 0. The first machine cycle after reset is idle: ale_o stays low and psen_no stays high.
- R9: req_data_i and fetch_addr_i are sampled only on the clock edge that ends phase 11. Changes at any other time do not alter the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_data_i | input | 1 | Kind of the next machine cycle: 1 = external data access, 0 = code fetch |
| fetch_addr_i | input | 16 | Fetch address of the next machine cycle |
| ea_i | input | 1 | External-access pin level; 0 forces external code |
| ale_off_i | input | 1 | Suppresses ALE while high |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_no | output | 1 | Program store enable, active low |
| ext_sel_o | output | 1 | The current fetch is served from external program memory |

## Verification
On every cycle, the assertions check that the phase counter steps and wraps correctly, that ALE and PSEN never overlap, that a PSEN pulse never appears in a data cycle or for an internal fetch, that each ALE pulse starts at the beginning of a half, and that the latched EA level stays fixed. The bench scenarios are needed for the exact phase positions of each pulse, the internal/external choice at the 8K boundary under both EA levels, the silencing by the ALE-off bit, the idle first cycle after reset, and the fact that inputs changed in mid-cycle or a late EA change have no effect.

// File: rtl/xbus_strobe_pkg.sv
package xbus_strobe_pkg;
  typedef enum logic {
    CYC_CODE = 1'b0,
    CYC_DATA = 1'b1
  } cyc_kind_e;
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
  parameter int CYC_CLKS = 12,
  localparam int CW = $clog2(CYC_CLKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  assign last_o = (cnt_o == CW'(CYC_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (last_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + 1'b1;
  end

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> cnt_o == '0);
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> cnt_o == CW'($past(cnt_o) + 1'b1));
endmodule

// File: rtl/xbus_code_sel.sv
module xbus_code_sel #(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] INT_TOP = 'h1FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ea_i,
  input  logic              capture_i,
  input  logic              is_code_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ext_o
);
  logic ea_done_q, ea_q;

  // EA is taken once, on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_done_q <= 1'b0;
      ea_q      <= 1'b0;
    end else if (!ea_done_q) begin
      ea_done_q <= 1'b1;
      ea_q      <= ea_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ext_o <= 1'b0;
    else if (capture_i) ext_o <= is_code_i && (!ea_q || (addr_i > INT_TOP));
  end

  p_ea_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ea_done_q |=> $stable(ea_q));
  p_int_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && ea_done_q && ea_q && addr_i <= INT_TOP) |=> !ext_o);
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_strobe_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                CYC_CLKS  = 12,
  parameter int                ALE_CLKS  = 2,
  parameter int                PSEN_CLKS = 3,
  parameter logic [ADDR_W-1:0] INT_TOP   = 'h1FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_data_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              ea_i,
  input  logic              ale_off_i,
  output logic              ale_o,
  output logic              psen_no,
  output logic              ext_sel_o
);
  localparam int CW   = $clog2(CYC_CLKS);
  localparam int HALF = CYC_CLKS / 2;

  logic [CW-1:0] cnt, sub;
  logic          last, second;
  logic          valid_q;
  cyc_kind_e     kind_q;
  logic          psen_act;

  xbus_phase_ctr #(.CYC_CLKS(CYC_CLKS)) i_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .last_o(last)
  );

  xbus_code_sel #(.ADDR_W(ADDR_W), .INT_TOP(INT_TOP)) i_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ea_i     (ea_i),
    .capture_i(last),
    .is_code_i(!req_data_i),
    .addr_i   (fetch_addr_i),
    .ext_o    (ext_sel_o)
  );

  // cycle request taken at the cycle boundary; first cycle after reset idles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      kind_q  <= CYC_CODE;
    end else if (last) begin
      valid_q <= 1'b1;
      kind_q  <= cyc_kind_e'(req_data_i);
    end
  end

  assign second = (cnt >= CW'(HALF));
  assign sub    = second ? cnt - CW'(HALF) : cnt;

  always_comb begin
    ale_o = valid_q && !ale_off_i && (sub < CW'(ALE_CLKS))
            && (kind_q == CYC_CODE || !second);
    psen_act = valid_q && (kind_q == CYC_CODE) && ext_sel_o
               && (sub >= CW'(ALE_CLKS)) && (sub < CW'(ALE_CLKS + PSEN_CLKS));
    psen_no = !psen_act;
  end

  p_no_overlap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_o && !psen_no));
  p_data_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && kind_q == CYC_DATA) |-> (psen_no && !ext_sel_o));
  p_int_no_psen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sel_o |-> psen_no);
  p_ale_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ale_o) && $stable(ale_off_i)) |-> sub == '0);
  p_idle_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> (!ale_o && psen_no));
endmodule

// File: tb/test_xbus_strobe_gen.sv
module test_xbus_strobe_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_data_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic        ea_i = 1'b1;
  logic        ale_off_i = 1'b0;
  logic        ale_o, psen_no, ext_sel_o;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  xbus_strobe_gen i_xbus_strobe_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_data_i  (req_data_i),
    .fetch_addr_i(fetch_addr_i),
    .ea_i        (ea_i),
    .ale_off_i   (ale_off_i),
    .ale_o       (ale_o),
    .psen_no     (psen_no),
    .ext_sel_o   (ext_sel_o)
  );

  // {data, ale_off, addr[15:0], expected ext} with EA latched high
  localparam logic [18:0] VECS [7] = '{
    {1'b0, 1'b0, 16'h2000, 1'b1},
    {1'b0, 1'b0, 16'h1FFF, 1'b0},
    {1'b1, 1'b0, 16'h2000, 1'b0},
    {1'b0, 1'b1, 16'hFFFF, 1'b1},
    {1'b0, 1'b0, 16'h0000, 1'b0},
    {1'b1, 1'b1, 16'h4000, 1'b0},
    {1'b0, 1'b0, 16'h8000, 1'b1}
  };

  task automatic chk(input string tag, input logic act, input logic exp, input int ph);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s phase %0d actual %b expected %b", tag, ph, act, exp);
    end
  endtask

  // one machine cycle, expectation derived from R1-style phase rules
  task automatic run_cycle(input logic data, input logic off, input logic ext, input logic flip);
    for (int j = 0; j < 12; j++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      begin
        int  h = j % 6;
        logic e_ale  = !off && (h < 2) && (!data || j < 6);
        logic e_psen = !(!data && ext && h >= 2 && h <= 4);
        chk(data ? "R3 ale" : (off ? "R6 ale" : "R1 ale"), ale_o, e_ale, j);
        chk(data ? "R3 psen" : (ext ? "R2 psen" : "R4 psen"), psen_no, e_psen, j);
        chk(flip ? "R9 ext" : "R5 ext", ext_sel_o, ext, j);
      end
      if (flip && j == 5) begin
        req_data_i   = ~req_data_i;
        fetch_addr_i = ~fetch_addr_i;
      end
    end
  endtask

  task automatic drive(input logic data, input logic off, input logic [15:0] a);
    req_data_i   = data;
    ale_off_i    = off;
    fetch_addr_i = a;
  endtask

  // reset pulse then idle first cycle; leaves bench at phase 11
  task automatic do_reset(input logic ea);
    @(negedge clk_i);
    rst_ni = 1'b0;
    ea_i   = ea;
    #1;
    chk("R8 rst ale", ale_o, 1'b0, 0);
    chk("R8 rst psen", psen_no, 1'b1, 0);
    chk("R8 rst ext", ext_sel_o, 1'b0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int j = 1; j < 12; j++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk("R8 idle ale", ale_o, 1'b0, j);
      chk("R8 idle psen", psen_no, 1'b1, j);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    drive(1'b0, 1'b0, 16'h2000);
    do_reset(1'b1);
    for (int v = 0; v < 7; v++) begin
      drive(VECS[v][18], VECS[v][17], VECS[v][16:1]);
      run_cycle(VECS[v][18], VECS[v][17], VECS[v][0], 1'b0);
    end
    // R7: late EA drop must not reroute a low fetch
    ea_i = 1'b0;
    drive(1'b0, 1'b0, 16'h0100);
    run_cycle(1'b0, 1'b0, 1'b0, 1'b0);
    // R9: inputs flipped mid-cycle do not alter the cycle
    drive(1'b0, 1'b0, 16'hC000);
    run_cycle(1'b0, 1'b0, 1'b1, 1'b1);
    // R8: mid-cycle reset, then EA latched low: R5 everything external
    drive(1'b0, 1'b0, 16'h0100);
    repeat (4) @(posedge clk_i);
    do_reset(1'b0);
    ea_i = 1'b1;
    run_cycle(1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 16'h1FFF);
    run_cycle(1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 16'h1FFF);
    run_cycle(1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 16'h3000);
    run_cycle(1'b0, 1'b0, 1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule